// File: doc/BRIEF.md
# Bit-Serial CRC Engine with Append and Check

This block computes a cyclic redundancy code one bit per enabled clock. The polynomial, register width and starting value are parameters, so one module covers many standard CRCs that are not reflected and have no final XOR. Data enters most significant bit first and updates a running remainder. The full remainder is always visible on a parallel output.

For transmission, the sender drives the message bits with `flush_i` low. It then raises `flush_i` for WIDTH enabled cycles. During that window `line_o` carries the remainder, top bit first, while the register shifts zeros in behind it. Outside flush, `line_o` simply repeats `din_i`, so the output follows the serial line as data and then CRC. For reception, a second copy absorbs the message and the CRC with `flush_i` held low. `zero_o` then reports a clean frame by showing an all-zero remainder.

A parameter picks either a synchronous reset or an asynchronous reset. The reset loads the starting value.

Top module: `serial_crc_unit`

## Requirements
- R1: Reset loads the register with SEED (0xFFFF by default), and with a non-zero SEED `zero_o` is low after reset.
- R2: While `en_i` is low, `crc_o` and `zero_o` keep their values whatever `din_i` and `flush_i` do.
- R3: With `flush_i` low, each enabled cycle absorbs one `din_i` bit, message most significant bit first. With the defaults (POLY 0x1021, SEED 0xFFFF) the register reads 0x29B1 after the ASCII bytes "123456789", 0xB915 after the byte 0x41, and 0xFFFF after no bits.
- R4: While `flush_i` is high, `line_o` equals bit WIDTH-1 of the register, and each enabled cycle shifts the register left by one with a zero entering bit 0. WIDTH such cycles therefore emit the CRC most significant bit first.
- R5: After WIDTH consecutive enabled flush cycles, `crc_o` is zero and `zero_o` is high.
- R6: While `flush_i` is low, `line_o` equals `din_i`.
- R7: `zero_o` is high exactly when every register bit is zero. Absorbing a message followed by its own CRC with `flush_i` low drives `zero_o` high. Absorbing the same stream with one CRC bit inverted leaves `zero_o` low.
- R8: With ASYNC_RST=1, raising `rst_i` loads SEED at once, without a clock edge. With ASYNC_RST=0, the register changes only at the next rising clock edge.
- R9: The parameters set the code. With WIDTH=8, POLY=0x07 and SEED=0x00, the register reads 0xF4 after the ASCII bytes "123456789".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Reset, active high; synchronous or asynchronous per ASYNC_RST |
| en_i | input | 1 | Clock enable; no update when low |
| din_i | input | 1 | Serial data bit |
| flush_i | input | 1 | High: shift the remainder out; low: absorb data |
| line_o | output | 1 | Serial line: `din_i` outside flush, register MSB during flush |
| zero_o | output | 1 | High when the register is all zero |
| crc_o | output | WIDTH | Current register contents |

## Verification
The in-line properties check several rules on every cycle: the register holds while the enable is low, a flush step moves every bit up one place and clears bit 0, reset leaves the seed in place, an all-zero register stays zero when it absorbs zero bits, and a full run of WIDTH flush cycles always ends with the zero flag high. None of those properties can tell whether the polynomial feedback gives the right code. That needs the bench's known-answer messages. The bench also covers what only a complete scenario shows: the CRC appearing on the line in order, a receiver accepting a correct frame and rejecting a corrupted one, and the difference in timing between the two reset styles.

// File: rtl/serial_crc_unit.sv
module serial_crc_unit #(
  parameter int unsigned          WIDTH     = 16,
  parameter logic [WIDTH-1:0]     POLY      = 16'h1021,
  parameter logic [WIDTH-1:0]     SEED      = 16'hFFFF,
  parameter bit                   ASYNC_RST = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             din_i,
  input  logic             flush_i,
  output logic             line_o,
  output logic             zero_o,
  output logic [WIDTH-1:0] crc_o
);

  localparam int unsigned RUN_W = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] rem_q;
  logic [WIDTH-1:0] rem_d;
  logic [WIDTH-1:0] shifted;
  logic             feedback;

  assign shifted  = {rem_q[WIDTH-2:0], 1'b0};
  assign feedback = rem_q[WIDTH-1] ^ din_i;
  assign rem_d    = flush_i ? shifted : (feedback ? (shifted ^ POLY) : shifted);

  generate
    if (ASYNC_RST) begin : g_arst
      always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i)     rem_q <= SEED;
        else if (en_i) rem_q <= rem_d;
      end
    end else begin : g_srst
      always_ff @(posedge clk_i) begin
        if (rst_i)     rem_q <= SEED;
        else if (en_i) rem_q <= rem_d;
      end
    end
  endgenerate

  assign crc_o  = rem_q;
  assign zero_o = (rem_q == '0);
  assign line_o = flush_i ? rem_q[WIDTH-1] : din_i;

  logic [RUN_W-1:0] flush_run;

  always_ff @(posedge clk_i) begin
    if (rst_i)
      flush_run <= '0;
    else if (en_i) begin
      if (!flush_i)
        flush_run <= '0;
      else if (flush_run != RUN_W'(WIDTH))
        flush_run <= flush_run + 1'b1;
    end
  end

  p_seed_after_reset_r1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (crc_o == SEED));

  p_hold_when_idle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (crc_o == $past(crc_o)));

  p_zero_absorbs_zero_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !flush_i && zero_o && !din_i) |=> zero_o);

  p_flush_step_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && flush_i) |=> (crc_o[WIDTH-1:1] == $past(crc_o[WIDTH-2:0])) && !crc_o[0]);

  p_flush_empties_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (flush_run == RUN_W'(WIDTH)) |-> zero_o);

endmodule

// File: tb/test_serial_crc_unit.sv
module test_serial_crc_unit;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic rst_a = 1'b0;
  logic en = 1'b0;
  logic din = 1'b0;
  logic flush = 1'b0;

  logic        line16, zero16;
  logic [15:0] crc16;
  logic        line8, zero8;
  logic [7:0]  crc8;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serial_crc_unit i_serial_crc_unit (
    .clk_i(clk), .rst_i(rst), .en_i(en), .din_i(din), .flush_i(flush),
    .line_o(line16), .zero_o(zero16), .crc_o(crc16)
  );

  serial_crc_unit #(.WIDTH(8), .POLY(8'h07), .SEED(8'h00), .ASYNC_RST(1'b1)) i_crc8 (
    .clk_i(clk), .rst_i(rst_a), .en_i(en), .din_i(din), .flush_i(flush),
    .line_o(line8), .zero_o(zero8), .crc_o(crc8)
  );

  localparam int NV = 3;
  localparam logic [71:0] V_DATA [NV] = '{72'h313233343536373839, 72'h41, 72'h0};
  localparam int          V_LEN  [NV] = '{72, 8, 0};
  localparam logic [15:0] V_EXP  [NV] = '{16'h29B1, 16'hB915, 16'hFFFF};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic d, input logic f);
    @(negedge clk);
    din = d; flush = f; en = 1'b1;
    @(posedge clk);
    #1 en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rst_a = 1'b1; en = 1'b0; flush = 1'b0; din = 1'b0;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0; rst_a = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    do_reset();
    #1;
    chk("R1 seed", 32'(crc16), 32'hFFFF);
    chk("R1 zero flag", 32'(zero16), 32'h0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      for (int i = V_LEN[v] - 1; i >= 0; i--) begin
        @(negedge clk);
        din = V_DATA[v][i]; flush = 1'b0; en = 1'b1;
        #1;
        if (i == V_LEN[v] - 1) chk("R6 line follows data", 32'(line16), 32'(V_DATA[v][i]));
        @(posedge clk);
        #1 en = 1'b0;
      end
      #1;
      chk("R3 absorbed crc", 32'(crc16), 32'(V_EXP[v]));
      for (int i = 15; i >= 0; i--) begin
        @(negedge clk);
        din = ~V_EXP[v][i]; flush = 1'b1; en = 1'b1;
        #1;
        chk("R4 flushed bit", 32'(line16), 32'(V_EXP[v][i]));
        @(posedge clk);
        #1 en = 1'b0;
      end
      #1;
      chk("R5 emptied", 32'(crc16), 32'h0);
      chk("R5 zero flag", 32'(zero16), 32'h1);

      do_reset();
      for (int i = V_LEN[v] - 1; i >= 0; i--) send(V_DATA[v][i], 1'b0);
      for (int i = 15; i >= 0; i--) send(V_EXP[v][i], 1'b0);
      #1;
      chk("R7 good frame match", 32'(zero16), 32'h1);

      do_reset();
      for (int i = V_LEN[v] - 1; i >= 0; i--) send(V_DATA[v][i], 1'b0);
      for (int i = 15; i >= 0; i--) send(V_EXP[v][i] ^ (i == 15), 1'b0);
      #1;
      chk("R7 bad frame no match", 32'(zero16), 32'h0);
    end

    do_reset();
    for (int i = 71; i >= 0; i--) send(V_DATA[0][i], 1'b0);
    #1;
    chk("R9 crc8 result", 32'(crc8), 32'hF4);

    held = crc16;
    @(negedge clk);
    en = 1'b0; din = 1'b1; flush = 1'b1;
    @(posedge clk);
    #1;
    chk("R2 hold crc", 32'(crc16), 32'(held));
    chk("R2 hold flag", 32'(zero16), 32'h0);
    @(negedge clk);
    flush = 1'b0; din = 1'b0;

    @(negedge clk);
    rst_a = 1'b1; rst = 1'b1;
    #1;
    chk("R8 async immediate", 32'(crc8), 32'h00);
    chk("R8 sync waits for edge", 32'(crc16), 32'h29B1);
    @(posedge clk);
    #1;
    chk("R8 sync after edge", 32'(crc16), 32'hFFFF);
    @(negedge clk);
    rst = 1'b0; rst_a = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule